// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a register-mapped timer that counts clock cycles in a 64-bit up-counter and compares the count with a 64-bit period. Software first programs the period, clears the count and selects periodic watchdog operation through two control registers. It then arms the watchdog by writing two fixed 16-bit keys, in a fixed order, into the key field of the watchdog control register.

Once armed, the block expects to be kicked regularly. A kick is the same two-key pair, and the second key restarts the count from zero. If the count reaches the period before a kick, the block latches a timeout flag and raises a one-cycle reset request for the system reset controller. From the first accepted key until a hardware reset, all timer configuration is frozen. Only the key field and the flag-clear bit still act.

The register bus is a plain 32-bit write/read port with a byte address, a write data word, a write enable and a combinational read data word. Register offsets: identification 0x00, counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, timer control 0x20, global control 0x24, watchdog control 0x28. Offset 0x04 reads zero.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, every counter, period and control register reads zero, `rstReq` is low, the block is disarmed and unlocked, and offset 0x00 reads the constant `ID_VALUE`.
- R2: While unlocked, a write to a counter half or period half is read back unchanged. The timer control register keeps only its mode field, bits 7:6. The global control register keeps only bits 3:0.
- R3: The 64-bit count advances by exactly one per clock only when all of these hold: the mode field equals 2, global control bits 1:0 are both 1, and global control bits 3:2 equal 2. The carry passes from the low half into the high half.
- R4: Arming needs a watchdog control (0x28) write with key 0xA5C6 in bits 31:16 and bit 14 set. That write moves the block to the pre-active state. Any other watchdog control write while disarmed leaves it disarmed.
- R5: In the pre-active state, key 0xDA7E moves the block to the active state and clears the count to zero. In the service state, key 0xDA7E also returns it to active and clears the count.
- R6: From the pre-active state onward, writes to offsets 0x10 through 0x24 are ignored. The count keeps running and the period and control registers keep their values.
- R7: A kick must be 0xA5C6 followed by 0xDA7E. In the active state, 0xDA7E alone changes nothing. In the service state, any other key returns the block to active without clearing the count.
- R8: While armed and counting, a count equal to the period produces the following at the next clock: `rstReq` goes high for one cycle, the flag (bit 15) is set, and the count returns to zero. While disarmed, the count still wraps at the period, but no flag is set and no pulse is produced.
- R9: The enable bit (bit 14) cannot be cleared by any write. Only a hardware reset clears it.
- R10: Writing 1 to bit 15 of watchdog control clears the timeout flag, in any state.
- R11: Watchdog control reads bit 14 as the enable and bit 15 as the flag. All other bits, including the key field, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Write data |
| regWe | input | 1 | Write enable, one write per cycle |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| rstReq | output | 1 | One-cycle reset request on timeout |

## Verification
The bench checks the exact clock on which the timeout fires. A design that compares one cycle early or late, or holds the request for more than one cycle, shows up there. The bench sends keys out of order and unknown keys in the service state. A design that restarts on the second key alone, or on any key, then shows a count that has been cleared. Writes to the configuration registers and to the enable bit after arming must all fail to change anything. A lock that starts only at the active state, or a clearable enable, shows up in the read-back values. A count set just below a 32-bit boundary shows whether the carry reaches the high half.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned CNT_W  = 2 * REG_W;

  localparam logic [ADDR_W-1:0] OFS_ID     = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_PER_LO = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_PER_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TCTL   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_GCTL   = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_WCTL   = 6'h28;

  localparam int unsigned MODE_LSB = 6;
  localparam int unsigned EN_BIT   = 14;
  localparam int unsigned FLAG_BIT = 15;
  localparam int unsigned KEY_LSB  = 16;
  localparam int unsigned KEY_W    = REG_W - KEY_LSB;

  typedef enum logic [1:0] {
    WD_OFF = 2'd0,
    WD_PRE = 2'd1,
    WD_ACT = 2'd2,
    WD_SVC = 2'd3
  } wdState_t;

  typedef struct packed {
    logic [1:0] wrCnt;
    logic [1:0] wrPer;
    logic       wrTimerCtl;
    logic       wrGlobalCtl;
    logic       restart;
    logic       clrFlag;
    logic       armed;
  } dpStrobes_t;
endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_ARM  = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_KICK = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              regWe,
  output dpStrobes_t        strobes
);
  wdState_t          state;
  wdState_t          stateNext;
  logic              wrCtl;
  logic              locked;
  logic              kickOk;
  logic [KEY_W-1:0]  key;

  assign key    = regWdata[KEY_LSB +: KEY_W];
  assign wrCtl  = regWe && (regAddr == OFS_WCTL);
  assign locked = (state != WD_OFF);

  always_comb begin
    stateNext = state;
    kickOk    = 1'b0;
    if (wrCtl) begin
      case (state)
        WD_OFF: if (key == KEY_ARM && regWdata[EN_BIT]) stateNext = WD_PRE;
        WD_PRE: if (key == KEY_KICK) begin
                  stateNext = WD_ACT;
                  kickOk    = 1'b1;
                end
        WD_ACT: if (key == KEY_ARM) stateNext = WD_SVC;
        WD_SVC: begin
                  stateNext = WD_ACT;
                  kickOk    = (key == KEY_KICK);
                end
        default: stateNext = WD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WD_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.wrCnt[0]    = regWe && !locked && (regAddr == OFS_CNT_LO);
    strobes.wrCnt[1]    = regWe && !locked && (regAddr == OFS_CNT_HI);
    strobes.wrPer[0]    = regWe && !locked && (regAddr == OFS_PER_LO);
    strobes.wrPer[1]    = regWe && !locked && (regAddr == OFS_PER_HI);
    strobes.wrTimerCtl  = regWe && !locked && (regAddr == OFS_TCTL);
    strobes.wrGlobalCtl = regWe && !locked && (regAddr == OFS_GCTL);
    strobes.restart     = kickOk;
    strobes.clrFlag     = wrCtl && regWdata[FLAG_BIT];
    strobes.armed       = locked;
  end

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (state != WD_OFF) |=> (state != WD_OFF)) else $error("enable cleared"); // R9

  AST_ARM_VIA_PRE: assert property (@(posedge clk) disable iff (!rstN)
    (state == WD_OFF) |=> (state == WD_OFF || state == WD_PRE)) else $error("skipped pre-active"); // R4
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter logic [REG_W-1:0] ID_VALUE = 32'h4B57_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              rstReq
);
  localparam int unsigned HALVES = CNT_W / REG_W;

  logic [CNT_W-1:0] cnt;
  wire  [CNT_W-1:0] perFull;
  logic [1:0]       modeSel;
  logic [3:0]       gctl;
  logic             toFlag;
  logic             running;
  logic             hit;
  logic             fire;

  for (genvar h = 0; h < HALVES; h++) begin : g_per
    logic [REG_W-1:0] half;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                half <= '0;
      else if (strobes.wrPer[h]) half <= regWdata;
    end
    assign perFull[h*REG_W +: REG_W] = half;
  end

  assign running = (modeSel == 2'd2) && (gctl[1:0] == 2'b11) && (gctl[3:2] == 2'd2);
  assign hit     = (cnt == perFull);
  assign fire    = running && hit && strobes.armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.restart) begin
      cnt <= '0;
    end else if (|strobes.wrCnt) begin
      for (int h = 0; h < HALVES; h++)
        if (strobes.wrCnt[h]) cnt[h*REG_W +: REG_W] <= regWdata;
    end else if (running) begin
      cnt <= hit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= '0;
      gctl    <= '0;
      toFlag  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (strobes.wrTimerCtl)  modeSel <= regWdata[MODE_LSB +: 2];
      if (strobes.wrGlobalCtl) gctl    <= regWdata[3:0];
      if (fire)                 toFlag  <= 1'b1;
      else if (strobes.clrFlag) toFlag  <= 1'b0;
      rstReq <= fire;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_ID:     regRdata = ID_VALUE;
      OFS_CNT_LO: regRdata = cnt[0 +: REG_W];
      OFS_CNT_HI: regRdata = cnt[REG_W +: REG_W];
      OFS_PER_LO: regRdata = perFull[0 +: REG_W];
      OFS_PER_HI: regRdata = perFull[REG_W +: REG_W];
      OFS_TCTL:   regRdata[MODE_LSB +: 2] = modeSel;
      OFS_GCTL:   regRdata[3:0] = gctl;
      OFS_WCTL: begin
        regRdata[EN_BIT]   = strobes.armed;
        regRdata[FLAG_BIT] = toFlag;
      end
      default:    regRdata = '0;
    endcase
  end

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> toFlag) else $error("pulse without flag"); // R8

  AST_TIMEOUT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> $past(strobes.armed)) else $error("timeout while disarmed"); // R8

  AST_KICK_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (cnt == '0)) else $error("kick did not clear"); // R5

  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.armed |=> ($stable(perFull) && $stable(modeSel) && $stable(gctl)))
    else $error("config changed while locked"); // R6
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter logic [KEY_W-1:0] KEY_ARM  = 16'hA5C6,
  parameter logic [KEY_W-1:0] KEY_KICK = 16'hDA7E,
  parameter logic [REG_W-1:0] ID_VALUE = 32'h4B57_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic              regWe,
  output logic [REG_W-1:0]  regRdata,
  output logic              rstReq
);
  dpStrobes_t strobes;

  kwd_ctrl #(
    .KEY_ARM (KEY_ARM),
    .KEY_KICK(KEY_KICK)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regWe   (regWe),
    .strobes (strobes)
  );

  kwd_datapath #(
    .ID_VALUE(ID_VALUE)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .rstReq  (rstReq)
  );
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] ID_EXP = 32'h4B57_0100;
  localparam int NV = 12;
  // {offset, write data, expected read-back}
  localparam logic [69:0] VEC [NV] = '{
    {6'h10, 32'h0000_0055, 32'h0000_0055},
    {6'h14, 32'h0000_0007, 32'h0000_0007},
    {6'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {6'h1C, 32'h1234_5678, 32'h1234_5678},
    {6'h20, 32'hFFFF_FFFF, 32'h0000_00C0},
    {6'h24, 32'hFFFF_FFFF, 32'h0000_000F},
    {6'h24, 32'h0000_000B, 32'h0000_000B},
    {6'h20, 32'h0000_0040, 32'h0000_0040},
    {6'h28, 32'h0000_4000, 32'h0000_0000},
    {6'h28, 32'hDA7E_4000, 32'h0000_0000},
    {6'h10, 32'h0000_0000, 32'h0000_0000},
    {6'h14, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWe = 1'b0;
  logic [31:0] regRdata;
  logic        rstReq;
  int checks = 0;
  int errors = 0;
  int pulseCount = 0;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .rstReq(rstReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rstN && rstReq) pulseCount++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [31:0] exp);
    regWe = 1'b0; regAddr = a;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic kick();
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h28, 32'hDA7E_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 rstReq", {31'b0, rstReq}, 32'h0);
    rdChk("R1 wctl", 6'h28, 32'h0);
    rdChk("R1 cntLo", 6'h10, 32'h0);
    rdChk("R1 perLo", 6'h18, 32'h0);
    rdChk("R1 id", 6'h00, ID_EXP);
    rdChk("R1 emu", 6'h04, 32'h0);

    // R2 read-back table, R4 rejected arming writes
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rdChk((VEC[i][69:64] == 6'h28) ? "R4 bad arm" : "R2 readback",
            VEC[i][69:64], VEC[i][31:0]);
    end

    // R3 run condition
    repeat (3) @(negedge clk);
    rdChk("R3 one-shot stopped", 6'h10, 32'h0);
    wr(6'h18, 32'd10);
    wr(6'h1C, 32'd0);
    wr(6'h20, 32'h80);
    repeat (3) @(negedge clk);
    rdChk("R3 counting", 6'h10, 32'd3);
    wr(6'h24, 32'h3);
    repeat (3) @(negedge clk);
    rdChk("R3 not watchdog mode", 6'h10, 32'd5);
    wr(6'h24, 32'hB);
    pulseCount = 0;
    repeat (20) @(negedge clk);
    check("R8 disarmed no pulse", pulseCount, 32'd0);
    rdChk("R8 disarmed no flag", 6'h28, 32'h0);

    // R3 carry into high half
    wr(6'h20, 32'h0);
    wr(6'h10, 32'hFFFF_FFFE);
    wr(6'h14, 32'h0);
    wr(6'h18, 32'h0);
    wr(6'h1C, 32'h1);
    wr(6'h20, 32'h80);
    repeat (2) @(negedge clk);
    rdChk("R3 carry lo", 6'h10, 32'h0);
    rdChk("R3 carry hi", 6'h14, 32'h1);

    // arm
    wr(6'h20, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h14, 32'h0);
    wr(6'h18, 32'd10);
    wr(6'h1C, 32'h0);
    wr(6'h20, 32'h80);
    wr(6'h28, 32'hA5C6_4000);
    rdChk("R4 pre-active", 6'h28, 32'h0000_4000);
    rdChk("R11 key reads zero", 6'h28, 32'h0000_4000);
    wr(6'h18, 32'd5);
    rdChk("R6 period locked", 6'h18, 32'd10);
    wr(6'h20, 32'h0);
    rdChk("R6 tctl locked", 6'h20, 32'h80);
    wr(6'h14, 32'h7);
    rdChk("R6 counter locked", 6'h14, 32'h0);
    wr(6'h28, 32'hDA7E_0000);
    rdChk("R5 active restart", 6'h10, 32'h0);

    // R5 regular kicks keep it quiet
    pulseCount = 0;
    for (int k = 0; k < 6; k++) begin
      kick();
      repeat (2) @(negedge clk);
    end
    kick();
    check("R5 kicks prevent timeout", pulseCount, 32'd0);

    // R7 ordering
    wr(6'h28, 32'hA5C6_0000);
    wr(6'h28, 32'h1234_0000);
    rdChk("R7 wrong key no restart", 6'h10, 32'd4);
    wr(6'h28, 32'hDA7E_0000);
    rdChk("R7 second key alone", 6'h10, 32'd6);
    kick();
    wr(6'h28, 32'h0);
    rdChk("R9 enable sticky", 6'h28, 32'h0000_4000);

    // R8 timeout timing
    pulseCount = 0;
    repeat (8) @(negedge clk);
    check("R8 no early pulse", {31'b0, rstReq}, 32'h0);
    @(negedge clk);
    check("R8 pulse high", {31'b0, rstReq}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, rstReq}, 32'h0);
    check("R8 pulse count", pulseCount, 32'd1);
    rdChk("R8 flag set", 6'h28, 32'h0000_C000);
    rdChk("R8 count wrapped", 6'h10, 32'd1);
    wr(6'h28, 32'h0000_8000);
    rdChk("R10 flag cleared", 6'h28, 32'h0000_4000);

    // R9 only hardware reset disarms
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rdChk("R9 reset disarms", 6'h28, 32'h0);
    rdChk("R1 period after reset", 6'h18, 32'h0);
    wr(6'h18, 32'd3);
    rdChk("R9 unlocked after reset", 6'h18, 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule